// File: doc/BRIEF.md
# Parallel Display Write Bridge

This block turns writes from a simple memory-mapped host port into write cycles on a parallel display bus of the 8080 / MIPI DBI type B kind. Every accepted host write produces exactly one bus cycle. In that cycle chip select goes low, the write strobe pulses low once, and the write data appears on a data bus that is 8 or 16 bits wide, chosen by parameter. The host port has a valid/ready handshake. Ready stays low for the whole bus cycle, so a master that streams writes is held off and loses nothing.

The data/command line is taken from one address bit, chosen by parameter. Software or a streaming DMA therefore reaches the command register and the pixel stream through two address windows. A streaming master increments the address on every pixel, so the selected bit must lie above the highest offset a frame can reach. Some examples with 16-bit pixels:

| Frame | Writes | Highest offset | Lowest usable bit |
|---|---|---|---|
| 240x240 | 57600 | 0xE0FF | 16 |
| 320x240 | 76800 | — | 17 |
| 480x320 | 153600 | — | 18 |
| 640x480 | 307200 | — | 19 |

Bit 0 is never usable, because it toggles on every access.

The block also drives an active-low display reset, which follows the block's own synchronised reset. It drives a read strobe that is always inactive. It synchronises the tearing-effect input and keeps a sticky flag of its rising edges, which the host clears.

Top module: `dbi_wr_bridge`

## Requirements
- R1: `dbi_dc` for a write equals bit `DC_BIT` (default 16) of the write address, captured when the write is accepted. A value of 0 marks a command and 1 marks pixel data.
- R2: Each accepted write yields exactly one strobe pulse, carrying its data, in the order of acceptance. Chip select goes low on the clock edge that accepts the write and stays low for SETUP_CYC+WR_LOW+WR_HIGH clocks.
- R3: The write strobe is low for exactly WR_LOW clocks and only while chip select is low. Chip select is low for SETUP_CYC clocks before the strobe falls.
- R4: `dbi_data` and `dbi_dc` hold steady from the fall of the strobe until at least one clock after it rises.
- R5: `wr_ready` is high exactly when no bus cycle is running, which is when chip select is high. A write held valid while the bus is busy is accepted later and is neither dropped nor duplicated.
- R6: Address bits other than `DC_BIT` have no effect on `dbi_dc`. An incrementing address stream below `DC_BIT` keeps one data/command level.
- R7: `dbi_rd_n` stays high at all times.
- R8: `dbi_te` passes through two synchronising flops. A rising edge sets `te_flag` on the third clock edge after the input rises. `te_flag` stays set until `te_clr` is high at a clock edge. A set and a clear at the same edge leave the flag set.
- R9: `dbi_rst_n` is low while `rst_n` is low and goes high on the second clock edge after `rst_n` is released.
- R10: During reset, `dbi_cs_n` and `dbi_wr_n` are high, `wr_ready` is low, and `te_flag` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Host write request |
| wr_ready | output | 1 | Bridge can accept a write |
| wr_addr | input | ADDR_W | Host write address; bit DC_BIT selects data or command |
| wr_data | input | BUS_W | Host write data |
| te_clr | input | 1 | Clears the tearing-effect flag |
| te_flag | output | 1 | Sticky tearing-effect rising-edge flag |
| dbi_cs_n | output | 1 | Display chip select, active low |
| dbi_wr_n | output | 1 | Display write strobe, active low |
| dbi_rd_n | output | 1 | Display read strobe, held inactive |
| dbi_dc | output | 1 | Data (1) or command (0) |
| dbi_data | output | BUS_W | Display data bus |
| dbi_rst_n | output | 1 | Display reset, active low |
| dbi_te | input | 1 | Tearing-effect input from the display |

## Verification
The hardest situation to reach from the ports is a write that is presented while the previous bus cycle is still running. The bridge must hold that write off and then issue it once, in order, with its own data/command level. The bench reaches it by calling its write task back to back. Each new write is raised during the bus cycle of the previous one and held until ready returns. A scoreboard then matches every strobe pulse against the queue of writes.

Address streams that toggle every bit below the select bit, and that set unrelated high bits, check that only bit 16 decides the data/command level. The tearing-effect flag has a case where set and clear land on the same clock edge. The bench times the clear pulse to the exact edge at which the synchronised rising edge arrives.

// File: rtl/dbi_wr_pkg.sv
package dbi_wr_pkg;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_LOW   = 2'd2,
    PH_HIGH  = 2'd3
  } dbi_phase_e;

  function automatic int unsigned dbi_max3(input int unsigned a, input int unsigned b,
                                           input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

  function automatic int unsigned dbi_cnt_w(input int unsigned top);
    return (top < 2) ? 1 : $clog2(top);
  endfunction

endpackage

// File: rtl/dbi_wr_timer.sv
module dbi_wr_timer
  import dbi_wr_pkg::*;
#(
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WR_LOW    = 2,
  parameter int unsigned WR_HIGH   = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic idle,
  output logic cs_n,
  output logic wr_n
);

  localparam int unsigned CNT_W = dbi_cnt_w(dbi_max3(SETUP_CYC, WR_LOW, WR_HIGH));
  localparam logic [CNT_W-1:0] SETUP_LD = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] LOW_LD   = CNT_W'(WR_LOW - 1);
  localparam logic [CNT_W-1:0] HIGH_LD  = CNT_W'(WR_HIGH - 1);

  dbi_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cs_n_q, wr_n_q;
  logic             cnt_zero;

  assign cnt_zero = (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    unique case (phase_q)
      PH_IDLE: begin
        if (start) begin
          phase_d = PH_SETUP;
          cnt_d   = SETUP_LD;
        end
      end
      PH_SETUP: begin
        if (cnt_zero) begin
          phase_d = PH_LOW;
          cnt_d   = LOW_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_LOW: begin
        if (cnt_zero) begin
          phase_d = PH_HIGH;
          cnt_d   = HIGH_LD;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      PH_HIGH: begin
        if (cnt_zero) begin
          phase_d = PH_IDLE;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: begin
        phase_d = PH_IDLE;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      cs_n_q  <= 1'b1;
      wr_n_q  <= 1'b1;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      cs_n_q  <= (phase_d == PH_IDLE);
      wr_n_q  <= (phase_d != PH_LOW);
    end
  end

  assign idle = (phase_q == PH_IDLE);
  assign cs_n = cs_n_q;
  assign wr_n = wr_n_q;

endmodule

// File: rtl/dbi_wr_hold.sv
module dbi_wr_hold #(
  parameter int unsigned BUS_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             sel_in,
  input  logic [BUS_W-1:0] data_in,
  output logic             dc,
  output logic [BUS_W-1:0] data
);

  logic             dc_q, dc_d;
  logic [BUS_W-1:0] data_q, data_d;

  always_comb begin
    dc_d   = dc_q;
    data_d = data_q;
    if (load) begin
      dc_d   = sel_in;
      data_d = data_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dc_q   <= 1'b1;
      data_q <= '0;
    end else begin
      dc_q   <= dc_d;
      data_q <= data_d;
    end
  end

  assign dc   = dc_q;
  assign data = data_q;

endmodule

// File: rtl/dbi_te_catch.sv
module dbi_te_catch (
  input  logic clk,
  input  logic rst_n,
  input  logic te_in,
  input  logic clr,
  output logic flag
);

  logic [2:0] sync_q, sync_d;
  logic       flag_q, flag_d;
  logic       rise;

  assign rise = sync_q[1] & ~sync_q[2];

  always_comb begin
    sync_d = {sync_q[1:0], te_in};
    flag_d = rise | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      flag_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

endmodule

// File: rtl/dbi_wr_bridge.sv
module dbi_wr_bridge
  import dbi_wr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned BUS_W     = 16,
  parameter int unsigned DC_BIT    = 16,
  parameter int unsigned SETUP_CYC = 1,
  parameter int unsigned WR_LOW    = 2,
  parameter int unsigned WR_HIGH   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [BUS_W-1:0]  wr_data,
  input  logic              te_clr,
  output logic              te_flag,
  output logic              dbi_cs_n,
  output logic              dbi_wr_n,
  output logic              dbi_rd_n,
  output logic              dbi_dc,
  output logic [BUS_W-1:0]  dbi_data,
  output logic              dbi_rst_n,
  input  logic              dbi_te
);

  localparam bit SEL_OK = (DC_BIT >= 1) && (DC_BIT < ADDR_W);

  logic [1:0] rsync_q;
  logic       srst_n;
  logic       idle;
  logic       start;
  logic       sel_bit;
  logic       unused_addr;

  // reset asserted at once, released on the second edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign srst_n = rsync_q[1];

  generate
    if (SEL_OK) begin : g_sel
      assign sel_bit = wr_addr[DC_BIT];
    end else begin : g_sel_fixed
      assign sel_bit = 1'b1;
    end
  endgenerate
  assign unused_addr = ^wr_addr;

  assign wr_ready = idle & srst_n;
  assign start    = wr_valid & wr_ready;

  dbi_wr_timer #(
    .SETUP_CYC(SETUP_CYC),
    .WR_LOW   (WR_LOW),
    .WR_HIGH  (WR_HIGH)
  ) u_timer (
    .clk  (clk),
    .rst_n(srst_n),
    .start(start),
    .idle (idle),
    .cs_n (dbi_cs_n),
    .wr_n (dbi_wr_n)
  );

  dbi_wr_hold #(
    .BUS_W(BUS_W)
  ) u_hold (
    .clk    (clk),
    .rst_n  (srst_n),
    .load   (start),
    .sel_in (sel_bit),
    .data_in(wr_data),
    .dc     (dbi_dc),
    .data   (dbi_data)
  );

  dbi_te_catch u_te (
    .clk  (clk),
    .rst_n(srst_n),
    .te_in(dbi_te),
    .clr  (te_clr),
    .flag (te_flag)
  );

  assign dbi_rd_n  = 1'b1;
  assign dbi_rst_n = srst_n;

endmodule

// File: rtl/dbi_wr_bridge_chk.sv
module dbi_wr_bridge_chk #(
  parameter int unsigned BUS_W  = 16,
  parameter int unsigned WR_LOW = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic             acc_dc,
  input logic             dbi_cs_n,
  input logic             dbi_wr_n,
  input logic             dbi_dc,
  input logic [BUS_W-1:0] dbi_data,
  input logic             te_clr,
  input logic             te_flag
);

  int unsigned low_run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        low_run_q <= 0;
    else if (dbi_wr_n) low_run_q <= 0;
    else               low_run_q <= low_run_q + 1;
  end

  // R1: the select bit at acceptance becomes the data/command level
  p_dc_from_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> (dbi_dc == $past(acc_dc)));

  // R2: an accepted write opens a bus cycle
  p_accept_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !dbi_cs_n);

  // R3: strobe only inside chip select
  p_strobe_in_cs_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !dbi_wr_n |-> !dbi_cs_n);

  // R3: strobe low width
  p_strobe_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbi_wr_n) |-> (low_run_q == WR_LOW));

  // R4: data and d/c held while strobe low and one clock after rise
  p_hold_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !dbi_wr_n |=> ($stable(dbi_data) && $stable(dbi_dc)));

  p_hold_after_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbi_wr_n) |=> ($stable(dbi_data) && $stable(dbi_dc)));

  // R5: no acceptance during a bus cycle
  p_busy_blocks_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !dbi_cs_n |-> !wr_ready);

  // R8: the flag only drops after a clear
  p_flag_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(te_flag) |-> $past(te_clr));

endmodule

bind dbi_wr_bridge dbi_wr_bridge_chk #(
  .BUS_W (BUS_W),
  .WR_LOW(WR_LOW)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_valid(wr_valid),
  .wr_ready(wr_ready),
  .acc_dc  (sel_bit),
  .dbi_cs_n(dbi_cs_n),
  .dbi_wr_n(dbi_wr_n),
  .dbi_dc  (dbi_dc),
  .dbi_data(dbi_data),
  .te_clr  (te_clr),
  .te_flag (te_flag)
);

// File: tb/dbi_wr_bridge_test.sv
`timescale 1ns/1ps
module dbi_wr_bridge_test;

  localparam int ADDR_W = 24;
  localparam int BUS_W  = 16;
  localparam int DC_BIT = 16;
  localparam int S_CYC  = 1;
  localparam int L_CYC  = 2;
  localparam int H_CYC  = 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              wr_valid;
  logic              wr_ready;
  logic [ADDR_W-1:0] wr_addr;
  logic [BUS_W-1:0]  wr_data;
  logic              te_clr;
  logic              te_flag;
  logic              dbi_cs_n, dbi_wr_n, dbi_rd_n, dbi_dc, dbi_rst_n, dbi_te;
  logic [BUS_W-1:0]  dbi_data;

  always #5 clk = ~clk;

  dbi_wr_bridge uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .te_clr(te_clr), .te_flag(te_flag),
    .dbi_cs_n(dbi_cs_n), .dbi_wr_n(dbi_wr_n), .dbi_rd_n(dbi_rd_n), .dbi_dc(dbi_dc),
    .dbi_data(dbi_data), .dbi_rst_n(dbi_rst_n), .dbi_te(dbi_te)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [BUS_W:0] exp_q[$];
  bit mon_en = 1'b0;
  bit done   = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // driver: holds the write until ready is seen, then queues the expectation
  task automatic send(input logic [ADDR_W-1:0] a, input logic [BUS_W-1:0] d);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_addr  = a;
    wr_data  = d;
    while (!wr_ready) @(negedge clk);
    exp_q.push_back({a[DC_BIT], d});
    @(negedge clk);
    wr_valid = 1'b0;
    wr_addr  = $urandom;
    wr_data  = $urandom;
  endtask

  // monitor / scoreboard
  logic            prev_wr = 1'b1, prev_cs = 1'b1, stab_pend = 1'b0;
  int              low_cnt = 0, cs_cnt = 0;
  logic [BUS_W:0]  cap, got;

  always @(negedge clk) begin
    if (mon_en) begin
      chk(dbi_rd_n == 1'b1, "R7 read strobe", dbi_rd_n, 1);
      chk(wr_ready == dbi_cs_n, "R5 ready vs busy", wr_ready, dbi_cs_n);
      if (!dbi_wr_n) chk(!dbi_cs_n, "R3 strobe outside cs", dbi_cs_n, 0);
      if (stab_pend) begin
        chk({dbi_dc, dbi_data} == cap, "R4 hold after rise", {dbi_dc, dbi_data}, cap);
        stab_pend = 1'b0;
      end
      if (!dbi_wr_n && prev_wr)
        chk(cs_cnt == S_CYC, "R3 setup length", cs_cnt, S_CYC);
      if (dbi_wr_n && !prev_wr) begin
        chk(low_cnt == L_CYC, "R3 strobe width", low_cnt, L_CYC);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R2 unexpected strobe", {dbi_dc, dbi_data}, 0);
        end else begin
          got = exp_q.pop_front();
          chk(dbi_data == got[BUS_W-1:0], "R2 data", dbi_data, got[BUS_W-1:0]);
          chk(dbi_dc == got[BUS_W], "R1 R6 dc level", dbi_dc, got[BUS_W]);
        end
        cap = {dbi_dc, dbi_data};
        stab_pend = 1'b1;
      end
      if (dbi_cs_n && !prev_cs)
        chk(cs_cnt == S_CYC + L_CYC + H_CYC, "R2 cs length", cs_cnt, S_CYC + L_CYC + H_CYC);
      low_cnt = dbi_wr_n ? 0 : low_cnt + 1;
      cs_cnt  = dbi_cs_n ? 0 : cs_cnt + 1;
      prev_wr = dbi_wr_n;
      prev_cs = dbi_cs_n;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_valid = 1'b0; wr_addr = '0; wr_data = '0;
    te_clr = 1'b0; dbi_te = 1'b0;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(dbi_cs_n && dbi_wr_n, "R10 strobes idle", {dbi_cs_n, dbi_wr_n}, 2'b11);
    chk(!wr_ready, "R10 ready low", wr_ready, 0);
    chk(!te_flag, "R10 te flag low", te_flag, 0);
    chk(!dbi_rst_n, "R9 display reset low", dbi_rst_n, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!dbi_rst_n, "R9 reset after one edge", dbi_rst_n, 0);
    @(negedge clk);
    chk(dbi_rst_n, "R9 reset released", dbi_rst_n, 1);
    chk(wr_ready, "R5 ready after reset", wr_ready, 1);
    prev_wr = dbi_wr_n; prev_cs = dbi_cs_n;
    mon_en = 1'b1;

    // command window, low bits toggling (R1, R6)
    send(24'h00FFFF, 16'h002A);
    for (int i = 0; i < 6; i++) send(24'h00FFF0 + 24'(i), 16'h1100 + 16'(i));
    // streaming pixel window crossing many low bits, back to back (R5, R6)
    for (int i = 0; i < 40; i++) send(24'h010000 + 24'(i * 97), 16'hA000 ^ 16'(i * 13));
    // unrelated high bits set (R6)
    send(24'h02FFFF, 16'h5555);
    send(24'h030000, 16'hAAAA);
    send(24'hFEFFFF, 16'h0F0F);
    send(24'hFF0001, 16'hF0F0);
    for (int i = 0; i < 20; i++) begin
      logic [ADDR_W-1:0] a;
      a = ADDR_W'($urandom);
      send(a, 16'($urandom));
    end
    while (exp_q.size() != 0 || !dbi_cs_n) @(negedge clk);
    repeat (3) @(negedge clk);

    // R8 tearing-effect latency
    dbi_te = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(!te_flag, "R8 flag not before third edge", te_flag, 0);
    @(negedge clk);
    chk(te_flag, "R8 flag on third edge", te_flag, 1);
    repeat (3) @(negedge clk);
    chk(te_flag, "R8 flag sticky", te_flag, 1);
    te_clr = 1'b1;
    @(negedge clk);
    te_clr = 1'b0;
    chk(!te_flag, "R8 flag cleared", te_flag, 0);
    dbi_te = 1'b0;
    repeat (4) @(negedge clk);
    chk(!te_flag, "R8 falling edge ignored", te_flag, 0);
    // set and clear on the same edge
    dbi_te = 1'b1;
    @(negedge clk); @(negedge clk);
    te_clr = 1'b1;
    @(negedge clk);
    te_clr = 1'b0;
    chk(te_flag, "R8 set wins over clear", te_flag, 1);

    repeat (4) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all writes issued", exp_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule